// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This block resolves the control-transfer part of a conditional branch and of a branch-and-link instruction. In the cycle an instruction is presented, it evaluates a three-bit test against the value of a general register, picks the new program counter, and prepares the link-register write. All of these are registered, so the results appear one clock later as a PC load strobe with its target and a register-write strobe with its data.

The test register value, the target register value and the already-incremented program counter come from the register read and fetch stages. The register file and the fetch logic are outside the block. When ra and rb name the same register on a branch-and-link, the target is the value read before the link write lands. Any opcode other than the two branch forms leaves both strobes low.

Top module: `branch_link_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, next_pc, pc_load, link_we and link_data are all zero.
- R2: Condition field values 0, 6 and 7 are never taken, and value 1 is always taken, whatever the test register holds.
- R3: Condition field value 2 is taken when the test register is all zero, and value 3 is taken when it is not all zero.
- R4: Condition field value 4 is taken when the test register's most significant bit is 0, and value 5 is taken when that bit is 1.
- R5: For opcode 8 with a taken condition, pc_load is 1 and next_pc equals the target value one clock later, and link_we stays 0.
- R6: For opcode 9, one clock later link_we is 1 and link_data equals the incremented PC, whether or not the branch is taken. When the branch is taken, pc_load is 1 and next_pc equals the target value.
- R7: On opcode 9, the new PC is the target value presented with the instruction, even when that value differs from the link data being written in the same cycle.
- R8: For any opcode other than 8 and 9, pc_load and link_we are 0 one clock later.
- R9: For opcode 8 or 9 with a condition that is not taken, pc_load is 0 and next_pc equals the incremented PC one clock later.
- R10: pc_load and link_we are single-cycle strobes. Back-to-back instructions each produce their own result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 5 | Opcode of the instruction in this stage |
| cond_i | input | 3 | Condition field, instruction bits 2..0 |
| test_val_i | input | XLEN | Value of the test register rc |
| target_val_i | input | XLEN | Value of the target register rb |
| pc_inc_i | input | XLEN | Program counter already advanced past this instruction |
| next_pc_o | output | XLEN | Registered new PC value |
| pc_load_o | output | 1 | Strobe: load next_pc_o into the PC |
| link_we_o | output | 1 | Strobe: write link_data_o into register ra |
| link_data_o | output | XLEN | Registered link value |

## Verification
Every result is due exactly one clock after the instruction's inputs are sampled, because each output passes through a single register. The bench changes inputs on the falling edge, lets one rising edge pass, and compares at the next falling edge. This keeps each check in the cycle the requirement names and away from the active edge. The back-to-back scenario then checks the following cycle as well, to confirm that a strobe does not outlive its instruction.

// File: rtl/blu_pkg.sv
package blu_pkg;
  localparam int unsigned OPW = 5;
  localparam logic [OPW-1:0] OP_BRANCH = 5'd8;
  localparam logic [OPW-1:0] OP_BR_LINK = 5'd9;

  typedef enum logic [2:0] {
    TST_NEVER   = 3'd0,
    TST_ALWAYS  = 3'd1,
    TST_ZERO    = 3'd2,
    TST_NONZERO = 3'd3,
    TST_POS     = 3'd4,
    TST_NEG     = 3'd5,
    TST_RSV6    = 3'd6,
    TST_RSV7    = 3'd7
  } test_code_e;
endpackage

// File: rtl/blu_cond_eval.sv
module blu_cond_eval
  import blu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]      cond_i,
  input  logic [XLEN-1:0] test_val_i,
  output logic            taken_o
);
  localparam int unsigned SIGN_BIT = XLEN - 1;

  logic is_zero;
  logic is_neg;

  assign is_zero = (test_val_i == '0);
  assign is_neg  = test_val_i[SIGN_BIT];

  always_comb begin
    unique case (test_code_e'(cond_i))
      TST_ALWAYS:  taken_o = 1'b1;
      TST_ZERO:    taken_o = is_zero;
      TST_NONZERO: taken_o = !is_zero;
      TST_POS:     taken_o = !is_neg;
      TST_NEG:     taken_o = is_neg;
      default:     taken_o = 1'b0; // never, plus reserved 6 and 7
    endcase
  end
endmodule

// File: rtl/blu_decode.sv
module blu_decode
  import blu_pkg::*;
(
  input  logic [OPW-1:0] opcode_i,
  output logic           is_branch_o,
  output logic           is_link_o
);
  always_comb begin
    is_branch_o = 1'b0;
    is_link_o   = 1'b0;
    if (opcode_i == OP_BRANCH) begin
      is_branch_o = 1'b1;
    end else if (opcode_i == OP_BR_LINK) begin
      is_branch_o = 1'b1;
      is_link_o   = 1'b1;
    end
  end
endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
  import blu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      opcode_i,
  input  logic [2:0]      cond_i,
  input  logic [XLEN-1:0] test_val_i,
  input  logic [XLEN-1:0] target_val_i,
  input  logic [XLEN-1:0] pc_inc_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            pc_load_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_data_o
);
  logic            taken;
  logic            is_branch;
  logic            is_link;

  logic [XLEN-1:0] pc_d;
  logic            pc_en;
  logic            load_d;
  logic            we_d;
  logic [XLEN-1:0] link_d;
  logic            link_en;

  blu_cond_eval #(.XLEN(XLEN)) u_cond (
    .cond_i     (cond_i),
    .test_val_i (test_val_i),
    .taken_o    (taken)
  );

  blu_decode u_dec (
    .opcode_i    (opcode_i),
    .is_branch_o (is_branch),
    .is_link_o   (is_link)
  );

  // Next state: target is taken from this cycle's read, ahead of the link write.
  always_comb begin
    pc_en   = is_branch;
    pc_d    = taken ? target_val_i : pc_inc_i;
    load_d  = is_branch && taken;
    we_d    = is_link;
    link_en = is_link;
    link_d  = pc_inc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load_o <= 1'b0;
      link_we_o <= 1'b0;
    end else begin
      pc_load_o <= load_d;
      link_we_o <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc_o <= '0;
    end else if (pc_en) begin
      next_pc_o <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_data_o <= '0;
    end else if (link_en) begin
      link_data_o <= link_d;
    end
  end

  p_never_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((opcode_i == OP_BRANCH || opcode_i == OP_BR_LINK) &&
     (cond_i == 3'd0 || cond_i == 3'd6 || cond_i == 3'd7)) |=> !pc_load_o);

  p_always_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((opcode_i == OP_BRANCH || opcode_i == OP_BR_LINK) && cond_i == 3'd1)
    |=> (pc_load_o && next_pc_o == $past(target_val_i)));

  p_plain_no_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_i == OP_BRANCH) |=> !link_we_o);

  p_link_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_i == OP_BR_LINK) |=> (link_we_o && link_data_o == $past(pc_inc_i)));

  p_other_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_i != OP_BRANCH && opcode_i != OP_BR_LINK) |=> (!pc_load_o && !link_we_o));

  p_fallthrough_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((opcode_i == OP_BRANCH || opcode_i == OP_BR_LINK) && cond_i == 3'd0)
    |=> (next_pc_o == $past(pc_inc_i)));
endmodule

// File: tb/branch_link_unit_tb.sv
module branch_link_unit_tb;
  localparam int XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic [4:0]      opcode;
  logic [2:0]      cond;
  logic [XLEN-1:0] test_val;
  logic [XLEN-1:0] target_val;
  logic [XLEN-1:0] pc_inc;
  logic [XLEN-1:0] next_pc;
  logic            pc_load;
  logic            link_we;
  logic [XLEN-1:0] link_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  branch_link_unit #(.XLEN(XLEN)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode_i     (opcode),
    .cond_i       (cond),
    .test_val_i   (test_val),
    .target_val_i (target_val),
    .pc_inc_i     (pc_inc),
    .next_pc_o    (next_pc),
    .pc_load_o    (pc_load),
    .link_we_o    (link_we),
    .link_data_o  (link_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit model_taken(input logic [2:0] c, input logic [XLEN-1:0] v);
    case (c)
      3'd1: return 1'b1;
      3'd2: return v == 0;
      3'd3: return v != 0;
      3'd4: return v[XLEN-1] == 1'b0;
      3'd5: return v[XLEN-1] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Drive on falling edge, let one rising edge pass, sample on the next falling edge.
  task automatic issue(input logic [4:0] op, input logic [2:0] c, input logic [XLEN-1:0] tv,
                       input logic [XLEN-1:0] tg, input logic [XLEN-1:0] pi);
    opcode = op; cond = c; test_val = tv; target_val = tg; pc_inc = pi;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue_and_check(input string req, input logic [4:0] op, input logic [2:0] c,
                                 input logic [XLEN-1:0] tv, input logic [XLEN-1:0] tg,
                                 input logic [XLEN-1:0] pi);
    bit tk;
    tk = model_taken(c, tv);
    issue(op, c, tv, tg, pi);
    chk({req, " pc_load"}, {31'b0, pc_load}, {31'b0, tk});
    chk({req, " next_pc"}, next_pc, tk ? tg : pi);
    chk({req, " link_we"}, {31'b0, link_we}, {31'b0, op == 5'd9});
    if (op == 5'd9) chk({req, " link_data"}, link_data, pi);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    opcode = 5'd0; cond = 3'd0; test_val = '0; target_val = '0; pc_inc = '0;
    repeat (3) @(negedge clk);
    chk("R1 next_pc", next_pc, '0);
    chk("R1 pc_load", {31'b0, pc_load}, '0);
    chk("R1 link_we", {31'b0, link_we}, '0);
    chk("R1 link_data", link_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle pc_load", {31'b0, pc_load}, '0);
    chk("R1 first cycle next_pc", next_pc, '0);
  endtask

  task automatic t_fixed_codes_r2();
    issue_and_check("R2 never", 5'd8, 3'd0, 32'h0, 32'h0000_1000, 32'h0000_0104);
    issue_and_check("R2 always", 5'd8, 3'd1, 32'h1234, 32'h0000_2000, 32'h0000_0108);
    issue_and_check("R2 code6", 5'd8, 3'd6, 32'h0, 32'h0000_3000, 32'h0000_010C);
    issue_and_check("R2 code7", 5'd8, 3'd7, 32'h8000_0000, 32'h0000_4000, 32'h0000_0110);
  endtask

  task automatic t_zero_codes_r3();
    issue_and_check("R3 zero-hit", 5'd8, 3'd2, 32'h0, 32'hAAAA_0000, 32'h0000_0204);
    issue_and_check("R3 zero-miss", 5'd8, 3'd2, 32'h0000_0001, 32'hAAAA_0010, 32'h0000_0208);
    issue_and_check("R3 nz-hit", 5'd8, 3'd3, 32'h8000_0000, 32'hAAAA_0020, 32'h0000_020C);
    issue_and_check("R3 nz-miss", 5'd8, 3'd3, 32'h0, 32'hAAAA_0030, 32'h0000_0210);
  endtask

  task automatic t_sign_codes_r4();
    issue_and_check("R4 pos-hit", 5'd8, 3'd4, 32'h7FFF_FFFF, 32'hBBBB_0000, 32'h0000_0304);
    issue_and_check("R4 pos-zero", 5'd8, 3'd4, 32'h0, 32'hBBBB_0010, 32'h0000_0308);
    issue_and_check("R4 pos-miss", 5'd8, 3'd4, 32'h8000_0000, 32'hBBBB_0020, 32'h0000_030C);
    issue_and_check("R4 neg-hit", 5'd8, 3'd5, 32'hFFFF_FFFF, 32'hBBBB_0030, 32'h0000_0310);
    issue_and_check("R4 neg-miss", 5'd8, 3'd5, 32'h0000_0001, 32'hBBBB_0040, 32'h0000_0314);
  endtask

  task automatic t_plain_r5_r9();
    issue_and_check("R5 taken", 5'd8, 3'd3, 32'h5, 32'hCCCC_0100, 32'h0000_0404);
    issue_and_check("R9 plain not taken", 5'd8, 3'd5, 32'h5, 32'hCCCC_0200, 32'h0000_0408);
    issue_and_check("R9 link not taken", 5'd9, 3'd0, 32'h5, 32'hCCCC_0300, 32'h0000_040C);
  endtask

  task automatic t_link_r6();
    issue_and_check("R6 link taken", 5'd9, 3'd1, 32'h0, 32'hDDDD_0000, 32'h0000_0504);
    issue_and_check("R6 link cond miss", 5'd9, 3'd2, 32'h9, 32'hDDDD_0010, 32'h0000_0508);
    issue_and_check("R6 link cond hit", 5'd9, 3'd5, 32'h8000_0001, 32'hDDDD_0020, 32'h0000_050C);
  endtask

  task automatic t_alias_r7();
    // ra == rb: the bench presents the pre-write rb value; new PC must be it, not the link value.
    issue(5'd9, 3'd1, 32'h0, 32'h0000_9000, 32'h0000_0604);
    chk("R7 next_pc is old rb", next_pc, 32'h0000_9000);
    chk("R7 link_data", link_data, 32'h0000_0604);
  endtask

  task automatic t_other_ops_r8();
    for (int op = 0; op < 32; op++) begin
      if (op == 8 || op == 9) continue;
      issue(5'(op), 3'd1, 32'h0, 32'hEEEE_0000, 32'h0000_0700);
      if (pc_load !== 1'b0 || link_we !== 1'b0) begin
        n_fails++;
        $display("FAIL R8 opcode %0d: actual load=%b we=%b expected 0/0", op, pc_load, link_we);
      end
      n_checks++;
    end
    chk("R8 link_data held", link_data, 32'h0000_0604);
  endtask

  task automatic t_back_to_back_r10();
    issue_and_check("R10 first", 5'd9, 3'd1, 32'h0, 32'hF000_0000, 32'h0000_0804);
    issue_and_check("R10 second", 5'd8, 3'd2, 32'h0, 32'hF000_0100, 32'h0000_0808);
    issue(5'd0, 3'd1, 32'h0, 32'h0, 32'h0);
    chk("R10 load drops", {31'b0, pc_load}, '0);
    chk("R10 we drops", {31'b0, link_we}, '0);
  endtask

  initial begin
    t_reset_r1();
    t_fixed_codes_r2();
    t_zero_codes_r3();
    t_sign_codes_r4();
    t_plain_r5_r9();
    t_link_r6();
    t_alias_r7();
    t_other_ops_r8();
    t_back_to_back_r10();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule